// File: doc/BRIEF.md
# Interrupt Request Scanner with Arm Control

This block keeps one request bit and one enable bit for every interrupt source. Sources are grouped into levels of 32, so source number `level*32 + bit` names one position. The block raises a pending flag while at least one source has both its request bit and its enable bit set. Requests are raised and dropped by per-source set and clear strobes. A small writable table maps each source position to a device number.

When an acknowledge strobe arrives, the block searches for the winning source. It tries level 0 first, then higher levels, and inside a level it tries bit 0 first. It clears the request bit of that one source only, and on the next cycle it presents the device number stored in the table for that position. If nothing is pending, it presents device number 0.

A 2-bit control command addressed to one source can enable, disable or disarm that source. The block reports whether each command leaves the source's arm state active or inactive.

The acknowledge result is tracked by a three-state machine:

- `ACK_IDLE`: no acknowledge in the previous cycle.
- `ACK_HIT`: the previous cycle acknowledged a pending source.
- `ACK_MISS`: the previous cycle acknowledged while nothing was pending.

The transitions are taken from any state:

- `ack` with a pending source goes to `ACK_HIT`.
- `ack` with no pending source goes to `ACK_MISS`.
- No `ack` goes to `ACK_IDLE`.

Top module: `irq_scan_arbiter`

## Requirements
- R1: `pend` is 1 exactly when some source has both its request bit and its enable bit set. A request or enable change takes effect on `pend` one cycle after its strobe or command.
- R2: On `ack`, the winner is the lowest level that has an active source, and within that level the lowest bit. One cycle later `ack_valid` is 1 and `ack_dev` holds table entry `level*32+bit`. In cycles without `ack`, `ack_valid` is 0.
- R3: An acknowledge clears the request bit of the winning source only. All other request bits keep their values.
- R4: An acknowledge while `pend` is 0 yields `ack_valid`=1 and `ack_dev`=0 one cycle later.
- R5: The command encodings are: `ctl_cmd`=2'b01 is enable, which sets the addressed source's enable bit, and 2'b10 is disable, which clears it. Both give `arm_upd`=1 and `arm_on`=1 one cycle later.
- R6: `ctl_cmd`=2'b11 is disarm. It clears the addressed source's enable bit and request bit, and gives `arm_upd`=1 and `arm_on`=0 one cycle later.
- R7: `ctl_cmd`=2'b00, or `ctl_valid`=0, changes no enable or request bit and gives `arm_upd`=0 one cycle later.
- R8: If a set strobe hits the same bit as an acknowledge clear in the same cycle, the request bit stays set.
- R9: A `req_clr` strobe clears the source's request bit. A set strobe on the same bit in the same cycle wins.
- R10: A table write takes effect from the next cycle. An acknowledge in the same cycle as the write returns the old entry.
- R11: After reset, all request bits, enable bits and table entries are 0. `pend`, `ack_valid`, `ack_dev` and `arm_upd` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_set | input | LEVELS*32 | Per-source request set strobes |
| req_clr | input | LEVELS*32 | Per-source request clear strobes |
| ctl_valid | input | 1 | Control command strobe |
| ctl_cmd | input | 2 | Command: 00 none, 01 enable, 10 disable, 11 disarm |
| ctl_src | input | IDX_W | Source addressed by the command |
| ack | input | 1 | Acknowledge strobe |
| tbl_we | input | 1 | Mapping table write enable |
| tbl_addr | input | IDX_W | Mapping table write address |
| tbl_wdata | input | DEV_W | Device number to store |
| pend | output | 1 | Some source is requesting and enabled |
| ack_valid | output | 1 | Acknowledge result present this cycle |
| ack_dev | output | DEV_W | Acknowledged device number |
| arm_upd | output | 1 | Previous command altered the arm state |
| arm_on | output | 1 | Resulting arm state (1 active, 0 inactive) |

## Verification
Two functions can fall in the same cycle: a raw request set on a source, and the clear that an acknowledge applies to the winning source. The bench provokes this by raising the set strobe of the winning source in the very cycle it pulses `ack`. It then judges the outcome in two ways: `pend` must stay high, and a second acknowledge must return the same device number. The same approach covers a set strobe against a clear strobe on one bit, and a table write against an acknowledge that reads the entry being written.

// File: rtl/irq_scan_pkg.sv
package irq_scan_pkg;

    localparam int unsigned WORD_BITS = 32;

    typedef enum logic [1:0] {
        CMD_NOP     = 2'b00,
        CMD_ENABLE  = 2'b01,
        CMD_DISABLE = 2'b10,
        CMD_DISARM  = 2'b11
    } ctl_cmd_e;

    typedef enum logic [1:0] {
        ACK_IDLE = 2'b00,
        ACK_HIT  = 2'b01,
        ACK_MISS = 2'b10
    } ack_state_e;

    // Position of the least significant set bit; 0 when the word is empty.
    function automatic logic [4:0] lowest_set(input logic [WORD_BITS-1:0] w);
        logic [4:0] pos;
        pos = 5'd0;
        for (int i = WORD_BITS - 1; i >= 0; i--) begin
            if (w[i]) pos = 5'(i);
        end
        return pos;
    endfunction

endpackage

// File: rtl/irq_src_bits.sv
module irq_src_bits
    import irq_scan_pkg::*;
#(
    parameter int unsigned N     = 64,
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_set,
    input  logic [N-1:0]     req_clr,
    input  logic             ack_take,
    input  logic [IDX_W-1:0] ack_idx,
    input  logic             ctl_valid,
    input  ctl_cmd_e         ctl_cmd,
    input  logic [IDX_W-1:0] ctl_src,
    output logic [N-1:0]     req_q,
    output logic [N-1:0]     en_q
);

    logic do_en, do_dis, do_darm;

    always_comb begin
        do_en   = ctl_valid && (ctl_cmd == CMD_ENABLE);
        do_dis  = ctl_valid && (ctl_cmd == CMD_DISABLE);
        do_darm = ctl_valid && (ctl_cmd == CMD_DISARM);
    end

    for (genvar g = 0; g < N; g++) begin : g_src
        logic hit_ctl, hit_ack;
        assign hit_ctl = (ctl_src == IDX_W'(g));
        assign hit_ack = ack_take && (ack_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                req_q[g] <= 1'b0;
            end else if (req_set[g]) begin
                req_q[g] <= 1'b1;
            end else if (req_clr[g] || hit_ack || (do_darm && hit_ctl)) begin
                req_q[g] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q[g] <= 1'b0;
            end else if (do_en && hit_ctl) begin
                en_q[g] <= 1'b1;
            end else if ((do_dis || do_darm) && hit_ctl) begin
                en_q[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/irq_prio_find.sv
module irq_prio_find
    import irq_scan_pkg::*;
#(
    parameter int unsigned LEVELS = 2,
    parameter int unsigned IDX_W  = 6
) (
    input  logic [LEVELS*WORD_BITS-1:0] active,
    output logic                        any,
    output logic [IDX_W-1:0]            idx
);

    localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;

    logic [LEVELS-1:0] lvl_any;
    logic [4:0]        lvl_bit [LEVELS];

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        assign lvl_any[l] = |active[l*WORD_BITS +: WORD_BITS];
        assign lvl_bit[l] = lowest_set(active[l*WORD_BITS +: WORD_BITS]);
    end

    logic [LVL_W-1:0] win_lvl;
    logic [4:0]       win_bit;

    always_comb begin
        win_lvl = '0;
        win_bit = '0;
        for (int l = LEVELS - 1; l >= 0; l--) begin
            if (lvl_any[l]) begin
                win_lvl = LVL_W'(l);
                win_bit = lvl_bit[l];
            end
        end
    end

    assign any = |lvl_any;
    assign idx = IDX_W'(IDX_W'(win_lvl) * IDX_W'(WORD_BITS) + IDX_W'(win_bit));

endmodule

// File: rtl/irq_map_table.sv
module irq_map_table #(
    parameter int unsigned ENTRIES = 64,
    parameter int unsigned IDX_W   = 6,
    parameter int unsigned DEV_W   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [DEV_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [DEV_W-1:0] rdata
);

    logic [DEV_W-1:0] entry_q [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[e] <= '0;
            end else if (we && (waddr == IDX_W'(e))) begin
                entry_q[e] <= wdata;
            end
        end
    end

    assign rdata = entry_q[raddr];

endmodule

// File: rtl/irq_scan_arbiter.sv
module irq_scan_arbiter
    import irq_scan_pkg::*;
#(
    parameter int unsigned LEVELS = 2,
    parameter int unsigned DEV_W  = 8,
    localparam int unsigned N     = LEVELS * WORD_BITS,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_set,
    input  logic [N-1:0]     req_clr,
    input  logic             ctl_valid,
    input  logic [1:0]       ctl_cmd,
    input  logic [IDX_W-1:0] ctl_src,
    input  logic             ack,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_addr,
    input  logic [DEV_W-1:0] tbl_wdata,
    output logic             pend,
    output logic             ack_valid,
    output logic [DEV_W-1:0] ack_dev,
    output logic             arm_upd,
    output logic             arm_on
);

    ctl_cmd_e         cmd;
    logic [N-1:0]     req_vec, en_vec;
    logic             win_any;
    logic [IDX_W-1:0] win_idx;
    logic [DEV_W-1:0] map_dev;
    ack_state_e       state_q, state_d;

    assign cmd = ctl_cmd_e'(ctl_cmd);

    irq_src_bits #(.N(N), .IDX_W(IDX_W)) u_bits (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_set  (req_set),
        .req_clr  (req_clr),
        .ack_take (ack && win_any),
        .ack_idx  (win_idx),
        .ctl_valid(ctl_valid),
        .ctl_cmd  (cmd),
        .ctl_src  (ctl_src),
        .req_q    (req_vec),
        .en_q     (en_vec)
    );

    irq_prio_find #(.LEVELS(LEVELS), .IDX_W(IDX_W)) u_find (
        .active(req_vec & en_vec),
        .any   (win_any),
        .idx   (win_idx)
    );

    irq_map_table #(.ENTRIES(N), .IDX_W(IDX_W), .DEV_W(DEV_W)) u_map (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (tbl_we),
        .waddr(tbl_addr),
        .wdata(tbl_wdata),
        .raddr(win_idx),
        .rdata(map_dev)
    );

    assign pend = win_any;

    always_comb begin
        unique case ({ack, win_any})
            2'b11:   state_d = ACK_HIT;
            2'b10:   state_d = ACK_MISS;
            default: state_d = ACK_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACK_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_dev <= '0;
            arm_upd <= 1'b0;
            arm_on  <= 1'b0;
        end else begin
            unique case (state_d)
                ACK_HIT:  ack_dev <= map_dev;
                ACK_MISS: ack_dev <= '0;
                default:  ack_dev <= ack_dev;
            endcase
            arm_upd <= ctl_valid && (cmd != CMD_NOP);
            if (ctl_valid && (cmd != CMD_NOP)) arm_on <= (cmd != CMD_DISARM);
        end
    end

    assign ack_valid = (state_q != ACK_IDLE);

endmodule

// File: rtl/irq_scan_checker.sv
module irq_scan_checker #(
    parameter int unsigned N     = 64,
    parameter int unsigned IDX_W = 6,
    parameter int unsigned DEV_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N-1:0]     req_set,
    input logic             ctl_valid,
    input logic [1:0]       ctl_cmd,
    input logic [IDX_W-1:0] ctl_src,
    input logic             ack,
    input logic             pend,
    input logic             ack_valid,
    input logic [DEV_W-1:0] ack_dev,
    input logic             arm_upd,
    input logic             arm_on,
    input logic [N-1:0]     req_vec,
    input logic [N-1:0]     en_vec
);

    p_pend_any_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pend == (|(req_vec & en_vec)));

    p_ack_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> ack_valid);

    p_ack_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !ack_valid);

    p_empty_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !pend) |=> (ack_dev == '0));

    p_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_cmd == 2'b01) |=> (en_vec[$past(ctl_src)] && arm_upd && arm_on));

    p_disable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_cmd == 2'b10) |=> (!en_vec[$past(ctl_src)] && arm_upd && arm_on));

    p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_valid && ctl_cmd == 2'b11) |=> (!en_vec[$past(ctl_src)] && arm_upd && !arm_on
            && (!req_vec[$past(ctl_src)] || $past(req_set[ctl_src]))));

    p_nop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_valid && ctl_cmd != 2'b00) |=> !arm_upd);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_set) |=> ((req_vec & $past(req_set)) == $past(req_set)));

endmodule

bind irq_scan_arbiter irq_scan_checker #(.N(N), .IDX_W(IDX_W), .DEV_W(DEV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_set  (req_set),
    .ctl_valid(ctl_valid),
    .ctl_cmd  (ctl_cmd),
    .ctl_src  (ctl_src),
    .ack      (ack),
    .pend     (pend),
    .ack_valid(ack_valid),
    .ack_dev  (ack_dev),
    .arm_upd  (arm_upd),
    .arm_on   (arm_on),
    .req_vec  (req_vec),
    .en_vec   (en_vec)
);

// File: tb/sim_irq_scan_arbiter.sv
module sim_irq_scan_arbiter;

    localparam int N = 64;
    localparam int IW = 6;
    localparam int DW = 8;

    localparam logic [2:0] OP_WTBL = 3'd0, OP_SET = 3'd1, OP_CLR = 3'd2, OP_ENA = 3'd3,
                           OP_DIS = 3'd4, OP_DARM = 3'd5, OP_ACK = 3'd6, OP_NOP = 3'd7;

    // {op, src, arg, expected pend, expected device}
    localparam int NV = 23;
    localparam logic [25:0] VECS [NV] = '{
        {OP_WTBL, 6'd3,  8'h13, 1'b0, 8'h00},
        {OP_WTBL, 6'd5,  8'h15, 1'b0, 8'h00},
        {OP_WTBL, 6'd33, 8'h41, 1'b0, 8'h00},
        {OP_WTBL, 6'd40, 8'h48, 1'b0, 8'h00},
        {OP_SET,  6'd5,  8'h00, 1'b0, 8'h00},
        {OP_ENA,  6'd5,  8'h00, 1'b1, 8'h00},
        {OP_SET,  6'd33, 8'h00, 1'b1, 8'h00},
        {OP_ENA,  6'd33, 8'h00, 1'b1, 8'h00},
        {OP_SET,  6'd3,  8'h00, 1'b1, 8'h00},
        {OP_ACK,  6'd0,  8'h00, 1'b1, 8'h15},
        {OP_ACK,  6'd0,  8'h00, 1'b0, 8'h41},
        {OP_ACK,  6'd0,  8'h00, 1'b0, 8'h00},
        {OP_ENA,  6'd3,  8'h00, 1'b1, 8'h00},
        {OP_SET,  6'd40, 8'h00, 1'b1, 8'h00},
        {OP_ENA,  6'd40, 8'h00, 1'b1, 8'h00},
        {OP_DIS,  6'd3,  8'h00, 1'b1, 8'h00},
        {OP_ACK,  6'd0,  8'h00, 1'b0, 8'h48},
        {OP_ENA,  6'd3,  8'h00, 1'b1, 8'h00},
        {OP_CLR,  6'd3,  8'h00, 1'b0, 8'h00},
        {OP_SET,  6'd33, 8'h00, 1'b1, 8'h00},
        {OP_DARM, 6'd33, 8'h00, 1'b0, 8'h00},
        {OP_ENA,  6'd33, 8'h00, 1'b0, 8'h00},
        {OP_ACK,  6'd0,  8'h00, 1'b0, 8'h00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0] req_set = '0, req_clr = '0;
    logic ctl_valid = 1'b0;
    logic [1:0] ctl_cmd = 2'b00;
    logic [IW-1:0] ctl_src = '0;
    logic ack = 1'b0, tbl_we = 1'b0;
    logic [IW-1:0] tbl_addr = '0;
    logic [DW-1:0] tbl_wdata = '0;
    logic pend, ack_valid, arm_upd, arm_on;
    logic [DW-1:0] ack_dev;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_scan_arbiter #(.LEVELS(2), .DEV_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_set(req_set), .req_clr(req_clr),
        .ctl_valid(ctl_valid), .ctl_cmd(ctl_cmd), .ctl_src(ctl_src), .ack(ack),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
        .pend(pend), .ack_valid(ack_valid), .ack_dev(ack_dev),
        .arm_upd(arm_upd), .arm_on(arm_on)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic idle();
        req_set = '0; req_clr = '0; ctl_valid = 1'b0; ctl_cmd = 2'b00;
        ack = 1'b0; tbl_we = 1'b0;
    endtask

    task automatic apply(input logic [2:0] op, input logic [IW-1:0] s, input logic [DW-1:0] a);
        case (op)
            OP_WTBL: begin tbl_we = 1'b1; tbl_addr = s; tbl_wdata = a; end
            OP_SET:  req_set[s] = 1'b1;
            OP_CLR:  req_clr[s] = 1'b1;
            OP_ENA:  begin ctl_valid = 1'b1; ctl_cmd = 2'b01; ctl_src = s; end
            OP_DIS:  begin ctl_valid = 1'b1; ctl_cmd = 2'b10; ctl_src = s; end
            OP_DARM: begin ctl_valid = 1'b1; ctl_cmd = 2'b11; ctl_src = s; end
            OP_ACK:  ack = 1'b1;
            default: begin ctl_valid = 1'b1; ctl_cmd = 2'b00; ctl_src = s; end
        endcase
    endtask

    // Drive already set, wait one cycle, return inputs to idle.
    task automatic cycle();
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 pend", pend, 0);
        chk("R11 ack_valid", ack_valid, 0);
        chk("R11 ack_dev", ack_dev, 0);
        chk("R11 arm_upd", arm_upd, 0);

        // Vector table: R1 R2 R3 R4 R5 R6 R9
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i][25:23], VECS[i][22:17], VECS[i][16:9]);
            cycle();
            chk($sformatf("R1 pend vec%0d", i), pend, VECS[i][8]);
            if (VECS[i][25:23] == OP_ACK) begin
                chk($sformatf("R2 ack_valid vec%0d", i), ack_valid, 1);
                chk($sformatf("R2 R3 R4 ack_dev vec%0d", i), ack_dev, VECS[i][7:0]);
            end else begin
                chk($sformatf("R2 idle vec%0d", i), ack_valid, 0);
            end
        end

        // R8: set and acknowledge-clear on the same bit
        apply(OP_SET, 6'd3, 0); cycle();
        chk("R8 setup pend", pend, 1);
        apply(OP_SET, 6'd3, 0); apply(OP_ACK, 0, 0); cycle();
        chk("R8 dev", ack_dev, 8'h13);
        chk("R8 pend kept", pend, 1);
        apply(OP_ACK, 0, 0); cycle();
        chk("R8 second dev", ack_dev, 8'h13);
        chk("R8 pend after", pend, 0);

        // R9: set beats clear on the same bit
        apply(OP_SET, 6'd5, 0); apply(OP_CLR, 6'd5, 0); cycle();
        chk("R9 set wins pend", pend, 1);
        apply(OP_ACK, 0, 0); cycle();
        chk("R9 dev", ack_dev, 8'h15);

        // R5 R6 R7 arm reporting
        apply(OP_ENA, 6'd7, 0); cycle();
        chk("R5 enable upd", arm_upd, 1); chk("R5 enable on", arm_on, 1);
        apply(OP_DIS, 6'd7, 0); cycle();
        chk("R5 disable upd", arm_upd, 1); chk("R5 disable on", arm_on, 1);
        apply(OP_DARM, 6'd7, 0); cycle();
        chk("R6 disarm upd", arm_upd, 1); chk("R6 disarm on", arm_on, 0);
        apply(OP_SET, 6'd40, 0); cycle();
        chk("R7 setup pend", pend, 1);
        apply(OP_NOP, 6'd40, 0); cycle();
        chk("R7 nop upd", arm_upd, 0);
        chk("R7 nop pend kept", pend, 1);
        apply(OP_ACK, 0, 0); cycle();
        chk("R7 request kept dev", ack_dev, 8'h48);

        // R10: write in the same cycle as acknowledge returns old entry
        apply(OP_SET, 6'd5, 0); cycle();
        apply(OP_WTBL, 6'd5, 8'h77); apply(OP_ACK, 0, 0); cycle();
        chk("R10 old entry", ack_dev, 8'h15);
        apply(OP_SET, 6'd5, 0); cycle();
        apply(OP_ACK, 0, 0); cycle();
        chk("R10 new entry", ack_dev, 8'h77);

        // R11: reset mid-run clears enables and table
        apply(OP_SET, 6'd40, 0); cycle();
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        chk("R11 pend after reset", pend, 0);
        apply(OP_SET, 6'd5, 0); cycle();
        chk("R11 enable cleared", pend, 0);
        apply(OP_ENA, 6'd5, 0); cycle();
        apply(OP_ACK, 0, 0); cycle();
        chk("R11 table cleared", ack_dev, 8'h00);
        chk("R11 ack_valid", ack_valid, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule